// File: doc/BRIEF.md
# Queued SPI Transfer Sequencer

This block walks a small queue of serial transfer entries. Software writes a 16-bit control word and pulses a start input. The sequencer then issues one transfer request for each queue entry. It begins at the new-queue pointer held in the control word and counts upward, modulo 16. The entry named by the end pointer is the last one. The serial shifter is not part of the block: it sits behind a one-cycle start strobe and a one-cycle done strobe. A fixed, parameterized idle gap follows every completed transfer, so that a slow peripheral sees its minimum deselect time before the next transfer begins.

Control writes are buffered. While the sequencer is idle, a write takes effect at once. While it is running, a write lands in a shadow copy. The pointer and wrap fields are copied into the live register when the current transfer completes. The interrupt enable is copied only when the end entry completes. A read always returns the live value. With wrap enabled, the sequencer does not stop after the end entry. It restarts either at entry 0 or at the new-queue pointer, chosen by a control bit.

Three sticky status flags drive a single interrupt line: queue finished, mode fault and halt acknowledge. Software clears a flag by writing a zero to its bit. The finished interrupt is latched, so dropping the enable later does not withdraw it.

Top module: `spi_queue_seq`

## Requirements
- R1: After reset, the control readback is 0x0000, all three status flags are 0, `irq` is 0, `busy` is 0 and `xfer_start` is 0.
- R2: The control word is laid out as: bit 15 finished-interrupt enable, bit 14 wrap enable, bit 13 wrap target (0 means entry 0, 1 means new-queue pointer), bits 11:8 end pointer, bits 3:0 new-queue pointer. Bits 12 and 7:4 always read 0. A write made while the sequencer is idle is visible on `ctl_rdata` in the next cycle.
- R3: A control write made while the sequencer is busy does not change `ctl_rdata` until the transfer in progress completes. At that completion, the wrap, wrap-target, end-pointer and new-queue-pointer fields take the written values.
- R4: A finished-interrupt enable written while busy stays pending until the end-pointer entry completes, and only then becomes active.
- R5: A start pulse loads `cur_ptr` with the new-queue pointer and issues a transfer. Each further transfer uses the previous pointer plus 1, modulo 16. In the cycle after the done strobe of the end-pointer entry, status bit 0 (finished) is 1. With wrap disabled, `busy` is 0 in that same cycle.
- R6: With wrap enabled, the entry that follows the end entry is entry 0 when the wrap target bit is 0, and the new-queue pointer when it is 1. Clearing wrap enable while running stops the sequencer at the next end-entry completion.
- R7: Exactly DLY_CYCLES idle cycles lie between the cycle in which `xfer_done` is 1 and the next `xfer_start` cycle. `xfer_start` is high for one cycle per transfer.
- R8: Status bit 1 (mode fault) is set by `mode_fault_evt` and status bit 2 (halt acknowledge) is set by `halt_ack_evt`. A status write with a 0 in a bit position clears that flag. A 1 leaves the flag unchanged.
- R9: `irq` is 1 when the mode-fault flag is set, or the halt-acknowledge flag is set, or the finished flag was raised while its enable was active. Clearing the enable does not drop the finished interrupt; clearing the finished flag does.
- R10: A start pulse while `busy` is 1 is ignored, and the queue continues in its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Live control word |
| stat_wr | input | 1 | Status write strobe (write 0 to clear) |
| stat_wdata | input | 3 | Status write data: bit 0 finished, bit 1 mode fault, bit 2 halt acknowledge |
| stat_flags | output | 3 | Sticky status flags, same bit order |
| mode_fault_evt | input | 1 | Mode fault event pulse |
| halt_ack_evt | input | 1 | Halt acknowledge event pulse |
| irq | output | 1 | Merged interrupt request |
| go | input | 1 | Start the queue |
| busy | output | 1 | Sequencer active |
| cur_ptr | output | 4 | Current queue pointer |
| xfer_start | output | 1 | One-cycle request to the shifter |
| xfer_done | input | 1 | One-cycle completion from the shifter |

## Verification
The bench runs queues that cross the 15-to-0 pointer rollover. It also runs both wrap targets, and catches a sequencer that wraps to the wrong entry or keeps running after wrap is cleared. It writes the control word in the middle of a transfer and reads it back before and after the boundary. A design that applied writes at once, or that applied the interrupt enable at an ordinary transfer boundary, would show the new value too early. It measures the idle gap after every transfer, which exposes an off-by-one delay counter. It also drops the enable after the finished interrupt has fired, and clears status bits one at a time, which exposes an interrupt that is not latched or a clear that touches the wrong flag.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
   localparam int PTR_W = 4;
   localparam int CTL_W = 16;
   localparam int N_FLAG = 3;

   typedef struct packed {
      logic             ie;
      logic             wrap;
      logic             wto;
      logic [PTR_W-1:0] endp;
      logic [PTR_W-1:0] newqp;
   } ctl_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DELAY = 2'd3
   } st_e;
endpackage

// File: rtl/spi_seq_ctl.sv
module spi_seq_ctl
   import spi_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             busy,
   input  logic             boundary,
   input  logic             end_hit,
   output logic             act_ie,
   output logic [PTR_W-1:0] act_endp,
   output logic [PTR_W-1:0] act_newqp,
   output logic             nxt_ie,
   output logic             nxt_wrap,
   output logic             nxt_wto,
   output logic [PTR_W-1:0] nxt_newqp,
   output logic [CTL_W-1:0] rdata
);
   ctl_t shad_q, act_q, nxt;
   logic unused_wbits;

   assign unused_wbits = ^{wdata[12], wdata[7:4]};

   always_comb begin
      nxt = shad_q;
      if (wr) begin
         nxt.ie    = wdata[15];
         nxt.wrap  = wdata[14];
         nxt.wto   = wdata[13];
         nxt.endp  = wdata[11:8];
         nxt.newqp = wdata[3:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shad_q <= '0;
         act_q  <= '0;
      end else begin
         shad_q <= nxt;
         if (!busy) begin
            act_q <= nxt;
         end else if (boundary) begin
            act_q.wrap  <= nxt.wrap;
            act_q.wto   <= nxt.wto;
            act_q.endp  <= nxt.endp;
            act_q.newqp <= nxt.newqp;
            if (end_hit) act_q.ie <= nxt.ie;
         end
      end
   end

   assign act_ie    = act_q.ie;
   assign act_endp  = act_q.endp;
   assign act_newqp = act_q.newqp;
   assign nxt_ie    = nxt.ie;
   assign nxt_wrap  = nxt.wrap;
   assign nxt_wto   = nxt.wto;
   assign nxt_newqp = nxt.newqp;
   assign rdata = {act_q.ie, act_q.wrap, act_q.wto, 1'b0,
                   act_q.endp, 4'b0000, act_q.newqp};
endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
   import spi_seq_pkg::*;
#(
   parameter int DLY_CYCLES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             xfer_done,
   input  logic [PTR_W-1:0] act_endp,
   input  logic [PTR_W-1:0] act_newqp,
   input  logic             nxt_wrap,
   input  logic             nxt_wto,
   input  logic [PTR_W-1:0] nxt_newqp,
   output logic             xfer_start,
   output logic             busy,
   output logic             boundary,
   output logic             end_hit,
   output logic [PTR_W-1:0] cur_ptr
);
   localparam st_e ST_AFTER = (DLY_CYCLES > 0) ? ST_DELAY : ST_ISSUE;

   st_e              st_q;
   logic [PTR_W-1:0] ptr_q;
   logic             dly_last;

   generate
      if (DLY_CYCLES > 0) begin : g_dly
         localparam int DW = $clog2(DLY_CYCLES + 1);
         logic [DW-1:0] cnt_q;
         assign dly_last = (cnt_q == DW'(DLY_CYCLES - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)               cnt_q <= '0;
            else if (st_q == ST_DELAY) cnt_q <= dly_last ? '0 : cnt_q + 1'b1;
         end
      end else begin : g_nodly
         assign dly_last = 1'b1;
      end
   endgenerate

   assign boundary   = (st_q == ST_WAIT) && xfer_done;
   assign end_hit    = (ptr_q == act_endp);
   assign busy       = (st_q != ST_IDLE);
   assign xfer_start = (st_q == ST_ISSUE);
   assign cur_ptr    = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         ptr_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (go) begin
               ptr_q <= act_newqp;
               st_q  <= ST_ISSUE;
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: if (xfer_done) begin
               if (!end_hit) begin
                  ptr_q <= ptr_q + 1'b1;
                  st_q  <= ST_AFTER;
               end else if (nxt_wrap) begin
                  ptr_q <= nxt_wto ? nxt_newqp : '0;
                  st_q  <= ST_AFTER;
               end else begin
                  st_q  <= ST_IDLE;
               end
            end
            ST_DELAY: if (dly_last) st_q <= ST_ISSUE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_seq_status.sv
module spi_seq_status
   import spi_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fin_set,
   input  logic              mf_evt,
   input  logic              ha_evt,
   input  logic              stat_wr,
   input  logic [N_FLAG-1:0] stat_wdata,
   input  logic              ie_eff,
   input  logic              act_ie,
   output logic [N_FLAG-1:0] flags,
   output logic              irq
);
   logic [N_FLAG-1:0] set_v;
   logic [N_FLAG-1:0] keep_v;
   logic              fin_irq_q;

   assign set_v = {ha_evt, mf_evt, fin_set};

   genvar gi;
   generate
      for (gi = 0; gi < N_FLAG; gi++) begin : g_flag
         logic f_q;
         assign keep_v[gi] = ~(stat_wr & ~stat_wdata[gi]);
         always_ff @(posedge clk) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= set_v[gi] | (f_q & keep_v[gi]);
         end
         assign flags[gi] = f_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) fin_irq_q <= 1'b0;
      else fin_irq_q <= (fin_set & ie_eff)
                      | (((flags[0] & act_ie) | fin_irq_q) & keep_v[0]);
   end

   assign irq = fin_irq_q | flags[1] | flags[2];
endmodule

// File: rtl/spi_queue_seq.sv
module spi_queue_seq
   import spi_seq_pkg::*;
#(
   parameter int DLY_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   input  logic              stat_wr,
   input  logic [N_FLAG-1:0] stat_wdata,
   output logic [N_FLAG-1:0] stat_flags,
   input  logic              mode_fault_evt,
   input  logic              halt_ack_evt,
   output logic              irq,
   input  logic              go,
   output logic              busy,
   output logic [PTR_W-1:0]  cur_ptr,
   output logic              xfer_start,
   input  logic              xfer_done
);
   generate
      if (DLY_CYCLES < 0 || DLY_CYCLES > 65535) begin : g_bad_dly
         $error("DLY_CYCLES must lie in 0..65535");
      end
      if (PTR_W != 4 || CTL_W != 16) begin : g_bad_layout
         $error("control layout needs a 4-bit pointer in a 16-bit word");
      end
   endgenerate

   logic             boundary, end_hit, fin_set, ie_eff;
   logic             act_ie, nxt_ie, nxt_wrap, nxt_wto;
   logic [PTR_W-1:0] act_endp, act_newqp, nxt_newqp;

   assign fin_set = boundary & end_hit;
   assign ie_eff  = fin_set ? nxt_ie : act_ie;

   spi_seq_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
      .busy(busy), .boundary(boundary), .end_hit(end_hit),
      .act_ie(act_ie), .act_endp(act_endp), .act_newqp(act_newqp),
      .nxt_ie(nxt_ie), .nxt_wrap(nxt_wrap), .nxt_wto(nxt_wto),
      .nxt_newqp(nxt_newqp), .rdata(ctl_rdata)
   );

   spi_seq_fsm #(.DLY_CYCLES(DLY_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .go(go), .xfer_done(xfer_done),
      .act_endp(act_endp), .act_newqp(act_newqp),
      .nxt_wrap(nxt_wrap), .nxt_wto(nxt_wto), .nxt_newqp(nxt_newqp),
      .xfer_start(xfer_start), .busy(busy), .boundary(boundary),
      .end_hit(end_hit), .cur_ptr(cur_ptr)
   );

   spi_seq_status u_stat (
      .clk(clk), .rst_n(rst_n), .fin_set(fin_set),
      .mf_evt(mode_fault_evt), .ha_evt(halt_ack_evt),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .ie_eff(ie_eff), .act_ie(act_ie),
      .flags(stat_flags), .irq(irq)
   );
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
   parameter int DLY_CYCLES = 3
) (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] ctl_rdata,
   input logic        stat_wr,
   input logic [2:0]  stat_flags,
   input logic        mode_fault_evt,
   input logic        irq,
   input logic        busy,
   input logic [3:0]  cur_ptr,
   input logic        xfer_start,
   input logic        xfer_done
);
   AST_FIN_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xfer_done && !xfer_start && cur_ptr == ctl_rdata[11:8]) |=> stat_flags[0]); // R5
   AST_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> busy); // R5
   AST_CTL_HOLD_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !xfer_done) |=> $stable(ctl_rdata)); // R3
   AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (DLY_CYCLES > 0 && xfer_done) |=> !xfer_start); // R7
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start); // R7
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !stat_wr) |=> irq); // R9
   AST_MODF_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_flags[1] && !mode_fault_evt) |=> !stat_flags[1]); // R8
endmodule

bind spi_queue_seq spi_seq_chk #(.DLY_CYCLES(DLY_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .stat_wr(stat_wr),
   .stat_flags(stat_flags), .mode_fault_evt(mode_fault_evt), .irq(irq),
   .busy(busy), .cur_ptr(cur_ptr), .xfer_start(xfer_start),
   .xfer_done(xfer_done)
);

// File: tb/test_spi_queue_seq.sv
`timescale 1ns/1ps
module test_spi_queue_seq;
   localparam int DLY = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] ctl_rdata;
   logic        stat_wr = 1'b0;
   logic [2:0]  stat_wdata = '0;
   logic [2:0]  stat_flags;
   logic        mode_fault_evt = 1'b0;
   logic        halt_ack_evt = 1'b0;
   logic        irq;
   logic        go = 1'b0;
   logic        busy;
   logic [3:0]  cur_ptr;
   logic        xfer_start;
   logic        xfer_done = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   spi_queue_seq #(.DLY_CYCLES(DLY)) i_spi_queue_seq (.*);

   function automatic logic [15:0] ctl_word(input bit ie, input bit wrap, input bit wto,
                                            input logic [3:0] endp, input logic [3:0] start);
      return {ie, wrap, wto, 1'b0, endp, 4'b0000, start};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [15:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic wr_stat(input logic [2:0] v);
      @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
      @(negedge clk); stat_wr = 1'b0;
   endtask

   task automatic pulse_go();
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
   endtask

   // Called in the cycle after a done strobe (gap 1) or right after pulse_go.
   task automatic wait_start(input string tag, input logic [3:0] exp_ptr, input int exp_gap);
      int g = 1;
      while (!xfer_start && g < 100) begin
         @(negedge clk); g++;
      end
      chk({tag, " start seen"}, xfer_start, 1'b1);
      chk({tag, " pointer"}, cur_ptr, exp_ptr);
      if (exp_gap >= 0) chk({tag, " R7 gap"}, g, exp_gap);
   endtask

   task automatic finish_xfer(input int lat);
      repeat (lat) @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
   endtask

   task automatic run_seq(input logic [3:0] start, input logic [3:0] endp, input bit ie);
      logic [3:0] p = start;
      bit first = 1;
      wr_ctl(ctl_word(ie, 1'b0, 1'b0, endp, start));
      pulse_go();
      forever begin
         wait_start("R5 seq", p, first ? -1 : DLY + 1);
         first = 0;
         finish_xfer(1 + int'($urandom % 3));
         if (p == endp) break;
         p = p + 4'd1;
      end
      chk("R5 finished flag", stat_flags[0], 1'b1);
      chk("R5 idle after end", busy, 1'b0);
      chk("R9 irq follows enable", irq, ie);
      wr_stat(3'b110);
      chk("R8 finished cleared", stat_flags, 3'b000);
      chk("R9 irq dropped", irq, 1'b0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ctl reset", ctl_rdata, 16'h0000);
      chk("R1 flags reset", stat_flags, 3'b000);
      chk("R1 irq reset", irq, 1'b0);
      chk("R1 busy reset", busy, 1'b0);
      chk("R1 start reset", xfer_start, 1'b0);

      // R2: idle write visible next cycle, reserved bits read 0
      wr_ctl(16'hFFFF);
      chk("R2 idle write readback", ctl_rdata, 16'hEF0F);
      wr_ctl(16'h0000);
      chk("R2 idle clear", ctl_rdata, 16'h0000);

      // R5 directed: rollover 14,15,0,1
      run_seq(4'hE, 4'h1, 1'b1);

      // R4: enable written mid-run waits for the end entry
      wr_ctl(ctl_word(1'b0, 1'b0, 1'b0, 4'h2, 4'h0));
      pulse_go();
      wait_start("R4 e0", 4'h0, -1);
      wr_ctl(ctl_word(1'b1, 1'b0, 1'b0, 4'h2, 4'h0));
      chk("R3 readback unchanged mid-xfer", ctl_rdata, 16'h0200);
      finish_xfer(1);
      chk("R4 enable still pending", ctl_rdata, 16'h0200);
      wait_start("R4 e1", 4'h1, DLY + 1);
      // R10: start pulse while busy is ignored
      pulse_go();
      finish_xfer(1);
      chk("R4 enable pending after e1", ctl_rdata, 16'h0200);
      wait_start("R10 e2 not restarted", 4'h2, DLY + 1);
      finish_xfer(2);
      chk("R4 enable active at end", ctl_rdata, 16'h8200);
      chk("R4 irq raised", irq, 1'b1);
      // R9: dropping enable keeps the finished interrupt
      wr_ctl(16'h0200);
      @(negedge clk); @(negedge clk);
      chk("R9 enable cleared", ctl_rdata, 16'h0200);
      chk("R9 irq kept after enable clear", irq, 1'b1);
      wr_stat(3'b110);
      chk("R9 irq gone with flag", irq, 1'b0);

      // R6: wrap to new-queue pointer, then clear wrap mid-run
      wr_ctl(ctl_word(1'b0, 1'b1, 1'b1, 4'h2, 4'h1));
      pulse_go();
      wait_start("R6 a1", 4'h1, -1); finish_xfer(1);
      wait_start("R6 a2", 4'h2, DLY + 1); finish_xfer(1);
      chk("R5 finished with wrap", stat_flags[0], 1'b1);
      chk("R6 still busy", busy, 1'b1);
      wait_start("R6 wrap to start ptr", 4'h1, DLY + 1);
      wr_ctl(ctl_word(1'b0, 1'b0, 1'b1, 4'h2, 4'h1));
      chk("R3 wrap bit unchanged mid-xfer", ctl_rdata, 16'h6201);
      finish_xfer(1);
      chk("R3 wrap bit applied at boundary", ctl_rdata, 16'h2201);
      wait_start("R6 b2", 4'h2, DLY + 1); finish_xfer(1);
      chk("R6 stopped after wrap cleared", busy, 1'b0);
      wr_stat(3'b110);

      // R6: wrap to entry 0
      wr_ctl(ctl_word(1'b0, 1'b1, 1'b0, 4'hF, 4'hD));
      pulse_go();
      wait_start("R6 D", 4'hD, -1); finish_xfer(1);
      wait_start("R6 E", 4'hE, DLY + 1); finish_xfer(1);
      wait_start("R6 F", 4'hF, DLY + 1);
      wr_ctl(ctl_word(1'b0, 1'b0, 1'b0, 4'hF, 4'hD));
      finish_xfer(1);
      chk("R6 idle when wrap cleared at end", busy, 1'b0);
      wr_stat(3'b110);
      wr_ctl(ctl_word(1'b0, 1'b1, 1'b0, 4'h1, 4'hF));
      pulse_go();
      wait_start("R6 F2", 4'hF, -1); finish_xfer(1);
      wait_start("R6 0", 4'h0, DLY + 1); finish_xfer(1);
      wait_start("R6 1", 4'h1, DLY + 1); finish_xfer(1);
      wait_start("R6 wrap to zero", 4'h0, DLY + 1);
      wr_ctl(ctl_word(1'b0, 1'b0, 1'b0, 4'h1, 4'hF));
      finish_xfer(1);
      wait_start("R6 last", 4'h1, DLY + 1); finish_xfer(1);
      chk("R6 stop", busy, 1'b0);
      wr_stat(3'b110);

      // R8 / R9: other sources
      @(negedge clk); mode_fault_evt = 1'b1;
      @(negedge clk); mode_fault_evt = 1'b0;
      chk("R8 mode fault flag", stat_flags, 3'b010);
      chk("R9 irq on mode fault", irq, 1'b1);
      @(negedge clk); halt_ack_evt = 1'b1;
      @(negedge clk); halt_ack_evt = 1'b0;
      chk("R8 halt flag", stat_flags, 3'b110);
      wr_stat(3'b101);
      chk("R8 clear mode fault only", stat_flags, 3'b100);
      chk("R9 irq on halt", irq, 1'b1);
      wr_stat(3'b111);
      chk("R8 write one no effect", stat_flags, 3'b100);
      wr_stat(3'b011);
      chk("R8 clear halt", stat_flags, 3'b000);
      chk("R9 irq clear", irq, 1'b0);

      // Random queues
      for (int k = 0; k < 14; k++) begin
         run_seq(4'($urandom % 16), 4'($urandom % 16), 1'($urandom % 2));
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule